// File: doc/BRIEF.md
# LIN Diagnostic Request Frame Decoder

This block sits behind a LIN slave's byte receiver. It takes one complete 8-byte master request frame at a time, along with a flag that says whether the frame's checksum and framing were good. It decides whether the frame is addressed to this node and which diagnostic service it carries. It then issues one action pulse to the flash engine: erase a page range, write one 32-bit word, run a range check, or reset the device. It can also update its own node address. The block keeps the open or closed state of the transfer window, which the download service opens and which gates word writes. For the services that reply, it prepares the 8-byte slave response frame.

Requests enter on a valid/ready stream. A frame is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a check result is outstanding, so the sender must hold the frame stable until it is taken. The response leaves on a second valid/ready stream. A response stays offered, unchanged, until the response slot takes it (`rsp_ready` high) or until the next request is accepted, which discards it. Action pulses last one cycle, one clock edge after acceptance, and cannot be stalled.

Byte k of a frame (k = 0 is the node address, 1 the PCI, 2 the service byte, 3 to 7 the data) sits at bits [8k+7:8k] of `req_bytes` and `rsp_bytes`. Multi-byte fields travel least significant byte first.

Top module: `lin_diag_decoder`

## Requirements
- R1: After reset the node address is INIT_NAD, the transfer window is closed, no response is offered, no action pulse is high and `req_ready` is high.
- R2: A good frame at the node address carrying 06, B2, identifier 00, 3A, 00 loads the response 06, F2, 3A, 00, function ID low, function ID high, 00, with byte 0 the node address. Any other identifier, and any other node address, loads no response.
- R3: A good frame carrying 06, B0, 3A, 00, then a function ID equal to FUNC_ID (low byte first), replaces the node address with byte 7. It is accepted at the node address or at 7F. A frame with another function ID leaves the address unchanged. This service loads no response.
- R4: A good addressed frame carrying 06, 31, FF, 00 pulses `erase_valid` with page {byte 6, byte 5} and count byte 7. A count of 0 gives no pulse.
- R5: A good addressed frame carrying 04, 34 with count N > 0 in byte 5 opens the transfer window for N × WORDS_PER_PAGE words. Each good addressed frame carrying 05, 36 inside the window pulses `wr_valid` with word {byte 6, byte 5, byte 4, byte 3}.
- R6: The window closes by itself after its last expected word. A transfer frame outside the window gives no pulse.
- R7: While the window is open, any frame at the node address whose PCI is not 05, whose service byte is not 36 or whose checksum flag is low closes it. Frames to other addresses leave it open.
- R8: A frame with the checksum flag low triggers no action, no address change and no response.
- R9: A good addressed frame carrying 06, 31, FF, 01 pulses `chk_req` with page and count, then holds `req_ready` low until `chk_done`. The cycle after `chk_done` it offers 05, 71, sum bytes low to high, FF.
- R10: A good addressed frame carrying 02, 11, 01 pulses `reset_req`.
- R11: An offered response holds its bytes until `rsp_ready` takes it, and it is withdrawn when the next request is accepted.
- R12: At most one action pulse (`erase_valid`, `wr_valid`, `chk_req`, `reset_req`) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request frame offered |
| req_ready | output | 1 | Request frame can be taken |
| req_bytes | input | 64 | Request frame, byte k at [8k+7:8k] |
| req_cksum_ok | input | 1 | Frame received without error |
| rsp_valid | output | 1 | Response frame offered |
| rsp_ready | input | 1 | Response slot takes the frame |
| rsp_bytes | output | 64 | Response frame, byte k at [8k+7:8k] |
| node_nad | output | 8 | Current node address |
| win_open | output | 1 | Transfer window open |
| erase_valid | output | 1 | Erase action pulse |
| erase_page | output | 16 | Erase start page |
| erase_count | output | 8 | Erase page count |
| wr_valid | output | 1 | Word write pulse |
| wr_word | output | 32 | Word to program |
| chk_req | output | 1 | Range check pulse |
| chk_page | output | 16 | Check start page |
| chk_count | output | 8 | Check page count |
| chk_done | input | 1 | Check result valid |
| chk_sum | input | 32 | Check result |
| reset_req | output | 1 | Device reset pulse |

## Verification
The bench sweeps window lengths of one to three pages on a two-word page. It counts write pulses to catch a window that closes one word early or late, and it sends one extra transfer frame that must be dropped. It then closes an open window with an addressed non-transfer frame and with a bad-checksum transfer frame, and checks that a frame to a foreign address does not close it. A design that ignored the foreign NAD would lose valid data, and one that ignored the close rule would program stray words. Other cases cover a broadcast address change with a wrong function ID, which a careless decoder would accept. They also cover a response that must survive idle cycles but vanish on the next request, and a check that must stall new requests until its sum returns.

// File: rtl/lin_diag_pkg.sv
package lin_diag_pkg;
  localparam logic [7:0] BCAST_NAD   = 8'h7F;
  localparam logic [7:0] SUPP_LO     = 8'h3A;
  localparam logic [7:0] SUPP_HI     = 8'h00;
  localparam logic [7:0] PCI_XFER    = 8'h05;
  localparam logic [7:0] SID_XFER    = 8'h36;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_ASSIGN, ACT_READID, ACT_ERASE,
    ACT_DLOAD, ACT_XFER, ACT_CHECK, ACT_RESET
  } act_e;
endpackage

// File: rtl/lin_diag_classify.sv
module lin_diag_classify
  import lin_diag_pkg::*;
#(
  parameter logic [15:0] FUNC_ID = 16'h0032
) (
  input  logic [63:0] frame_i,
  input  logic        ok_i,
  input  logic [7:0]  nad_i,
  output act_e        act_o,
  output logic        kill_o
);
  logic [7:0] b [8];
  logic       own;

  always_comb begin
    for (int i = 0; i < 8; i++) b[i] = frame_i[8*i +: 8];
  end

  assign own    = (b[0] == nad_i);
  // an addressed frame that is not shaped as a good transfer ends the window
  assign kill_o = own && (!ok_i || b[1] != PCI_XFER || b[2] != SID_XFER);

  always_comb begin
    act_o = ACT_NONE;
    if (ok_i) begin
      if ((own || b[0] == BCAST_NAD) && b[1] == 8'h06 && b[2] == 8'hB0 &&
          b[3] == SUPP_LO && b[4] == SUPP_HI && {b[6], b[5]} == FUNC_ID)
        act_o = ACT_ASSIGN;
      else if (own) begin
        unique case ({b[1], b[2]})
          {8'h06, 8'hB2}:
            if (b[3] == 8'h00 && b[4] == SUPP_LO && b[5] == SUPP_HI) act_o = ACT_READID;
          {8'h06, 8'h31}:
            if (b[3] == 8'hFF && b[4] == 8'h00 && b[7] != 8'h00) act_o = ACT_ERASE;
            else if (b[3] == 8'hFF && b[4] == 8'h01) act_o = ACT_CHECK;
          {8'h04, 8'h34}:
            if (b[5] != 8'h00) act_o = ACT_DLOAD;
          {PCI_XFER, SID_XFER}:
            act_o = ACT_XFER;
          {8'h02, 8'h11}:
            if (b[3] == 8'h01) act_o = ACT_RESET;
          default: act_o = ACT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_diag_window.sv
module lin_diag_window #(
  parameter int WORDS_PER_PAGE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open_i,
  input  logic [7:0] pages_i,
  input  logic       kill_i,
  input  logic       word_i,
  output logic       open_o
);
  localparam int RW = 8 + $clog2(WORDS_PER_PAGE + 1);
  logic [RW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      rem_q  <= '0;
    end else if (open_i) begin
      open_o <= 1'b1;
      rem_q  <= RW'(pages_i) * RW'(WORDS_PER_PAGE);
    end else if (kill_i) begin
      open_o <= 1'b0;
    end else if (word_i && open_o) begin
      rem_q <= rem_q - RW'(1);
      if (rem_q == RW'(1)) open_o <= 1'b0;
    end
  end

  AST_WIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |-> rem_q != '0); // R6
  AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !open_o && !open_i |=> !open_o); // R5
endmodule

// File: rtl/lin_diag_resp.sv
module lin_diag_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [63:0] bytes_i,
  input  logic        drop_i,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [63:0] rsp_bytes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bytes <= '0;
    end else if (load_i) begin
      rsp_valid <= 1'b1;
      rsp_bytes <= bytes_i;
    end else if (drop_i || rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && !drop_i && !load_i |=> rsp_valid && $stable(rsp_bytes)); // R11
endmodule

// File: rtl/lin_diag_decoder.sv
module lin_diag_decoder
  import lin_diag_pkg::*;
#(
  parameter logic [7:0]  INIT_NAD       = 8'h10,
  parameter logic [15:0] FUNC_ID        = 16'h0032,
  parameter int          WORDS_PER_PAGE = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_bytes,
  input  logic        req_cksum_ok,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_bytes,
  output logic [7:0]  node_nad,
  output logic        win_open,
  output logic        erase_valid,
  output logic [15:0] erase_page,
  output logic [7:0]  erase_count,
  output logic        wr_valid,
  output logic [31:0] wr_word,
  output logic        chk_req,
  output logic [15:0] chk_page,
  output logic [7:0]  chk_count,
  input  logic        chk_done,
  input  logic [31:0] chk_sum,
  output logic        reset_req
);
  act_e        act;
  logic        kill, take, chk_busy, wr_fire, rsp_load;
  logic [63:0] rsp_next;

  assign req_ready = !chk_busy;
  assign take      = req_valid && req_ready;
  assign wr_fire   = take && act == ACT_XFER && win_open;

  lin_diag_classify #(.FUNC_ID(FUNC_ID)) cls_i (
    .frame_i(req_bytes), .ok_i(req_cksum_ok), .nad_i(node_nad),
    .act_o(act), .kill_o(kill)
  );

  lin_diag_window #(.WORDS_PER_PAGE(WORDS_PER_PAGE)) win_i (
    .clk(clk), .rst_n(rst_n),
    .open_i(take && act == ACT_DLOAD), .pages_i(req_bytes[47:40]),
    .kill_i(take && kill), .word_i(wr_fire), .open_o(win_open)
  );

  always_comb begin
    rsp_load = 1'b0;
    rsp_next = '0;
    if (chk_busy && chk_done) begin
      rsp_load = 1'b1;
      rsp_next = {8'hFF, chk_sum[31:24], chk_sum[23:16], chk_sum[15:8], chk_sum[7:0],
                  8'h71, 8'h05, node_nad};
    end else if (take && act == ACT_READID) begin
      rsp_load = 1'b1;
      rsp_next = {8'h00, FUNC_ID[15:8], FUNC_ID[7:0], SUPP_HI, SUPP_LO,
                  8'hF2, 8'h06, node_nad};
    end
  end

  lin_diag_resp rsp_i (
    .clk(clk), .rst_n(rst_n), .load_i(rsp_load), .bytes_i(rsp_next),
    .drop_i(take), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_bytes(rsp_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_nad    <= INIT_NAD;
      erase_valid <= 1'b0;
      erase_page  <= '0;
      erase_count <= '0;
      wr_valid    <= 1'b0;
      wr_word     <= '0;
      chk_req     <= 1'b0;
      chk_page    <= '0;
      chk_count   <= '0;
      chk_busy    <= 1'b0;
      reset_req   <= 1'b0;
    end else begin
      erase_valid <= take && act == ACT_ERASE;
      wr_valid    <= wr_fire;
      chk_req     <= take && act == ACT_CHECK;
      reset_req   <= take && act == ACT_RESET;
      if (take && act == ACT_ASSIGN) node_nad <= req_bytes[63:56];
      if (take && act == ACT_ERASE) begin
        erase_page  <= req_bytes[55:40];
        erase_count <= req_bytes[63:56];
      end
      if (wr_fire) wr_word <= req_bytes[55:24];
      if (take && act == ACT_CHECK) begin
        chk_page  <= req_bytes[55:40];
        chk_count <= req_bytes[63:56];
        chk_busy  <= 1'b1;
      end else if (chk_done) begin
        chk_busy <= 1'b0;
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_valid, wr_valid, chk_req, reset_req})); // R12
  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(win_open)); // R6
  AST_CHK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> !req_ready); // R9
  AST_BAD_NO_NAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_cksum_ok |=> $stable(node_nad)); // R8
endmodule

// File: tb/lin_diag_decoder_tb_top.sv
module lin_diag_decoder_tb_top;
  localparam logic [7:0]  NAD0 = 8'h10;
  localparam logic [15:0] FID  = 16'h0032;
  localparam int          WPP  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_cksum_ok = 1'b0, rsp_ready = 1'b0, chk_done = 1'b0;
  logic [63:0] req_bytes = '0;
  logic [31:0] chk_sum = '0;
  logic req_ready, rsp_valid, win_open, erase_valid, wr_valid, chk_req, reset_req;
  logic [63:0] rsp_bytes;
  logic [7:0]  node_nad, erase_count, chk_count;
  logic [15:0] erase_page, chk_page;
  logic [31:0] wr_word;

  int tests = 0, fails = 0;
  bit done = 0;
  logic c_erase, c_wr, c_chk, c_rst;
  logic [31:0] c_word;

  always #4 clk = ~clk;

  lin_diag_decoder #(.INIT_NAD(NAD0), .FUNC_ID(FID), .WORDS_PER_PAGE(WPP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bytes(req_bytes), .req_cksum_ok(req_cksum_ok), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_bytes(rsp_bytes), .node_nad(node_nad), .win_open(win_open),
    .erase_valid(erase_valid), .erase_page(erase_page), .erase_count(erase_count),
    .wr_valid(wr_valid), .wr_word(wr_word), .chk_req(chk_req), .chk_page(chk_page),
    .chk_count(chk_count), .chk_done(chk_done), .chk_sum(chk_sum), .reset_req(reset_req)
  );

  function automatic logic [63:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    return {b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [63:0] xfer(input logic [7:0] nad, input logic [31:0] w);
    return mk(nad, 8'h05, 8'h36, w[7:0], w[15:8], w[23:16], w[31:24], 8'hFF);
  endfunction

  task automatic check(input bit cond, input string req, input logic [63:0] act, exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] f, input logic ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_bytes = f; req_cksum_ok = ok;
    @(negedge clk);
    req_valid = 1'b0;
    c_erase = erase_valid; c_wr = wr_valid; c_word = wr_word;
    c_chk = chk_req; c_rst = reset_req;
  endtask

  task automatic serve;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(node_nad == NAD0 && !win_open && !rsp_valid && req_ready &&
          !erase_valid && !wr_valid && !chk_req && !reset_req,
          "R1", {node_nad, 7'd0, win_open, 7'd0, rsp_valid, 7'd0, req_ready}, {NAD0, 24'h000001});

    // R2 read identifier 0
    send(mk(NAD0, 8'h06, 8'hB2, 8'h00, 8'h3A, 8'h00, 8'hFF, 8'hFF), 1'b1);
    exp = mk(NAD0, 8'h06, 8'hF2, 8'h3A, 8'h00, FID[7:0], FID[15:8], 8'h00);
    check(rsp_valid && rsp_bytes == exp, "R2", rsp_bytes, exp);
    // R11 held over idle cycles, then taken by the slot
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_bytes == exp, "R11 hold", rsp_bytes, exp);
    serve();
    check(!rsp_valid, "R11 served", 64'(rsp_valid), 64'd0);
    // R2 unsupported identifier and foreign NAD give nothing
    send(mk(NAD0, 8'h06, 8'hB2, 8'h05, 8'h3A, 8'h00, 8'hFF, 8'hFF), 1'b1);
    check(!rsp_valid, "R2 other id", 64'(rsp_valid), 64'd0);
    send(mk(8'h33, 8'h06, 8'hB2, 8'h00, 8'h3A, 8'h00, 8'hFF, 8'hFF), 1'b1);
    check(!rsp_valid, "R2 other nad", 64'(rsp_valid), 64'd0);
    // R11 next request withdraws a pending response
    send(mk(NAD0, 8'h06, 8'hB2, 8'h00, 8'h3A, 8'h00, 8'hFF, 8'hFF), 1'b1);
    send(mk(8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1'b1);
    check(!rsp_valid, "R11 withdraw", 64'(rsp_valid), 64'd0);

    // R3 assign at broadcast: wrong then right function ID
    send(mk(8'h7F, 8'h06, 8'hB0, 8'h3A, 8'h00, 8'h33, 8'h00, 8'h22), 1'b1);
    check(node_nad == NAD0, "R3 wrong fid", 64'(node_nad), 64'(NAD0));
    send(mk(8'h7F, 8'h06, 8'hB0, 8'h3A, 8'h00, FID[7:0], FID[15:8], 8'h22), 1'b1);
    check(node_nad == 8'h22 && !rsp_valid, "R3 broadcast", 64'(node_nad), 64'h22);
    send(mk(8'h22, 8'h06, 8'hB0, 8'h3A, 8'h00, FID[7:0], FID[15:8], NAD0), 1'b1);
    check(node_nad == NAD0, "R3 own", 64'(node_nad), 64'(NAD0));
    // R8 bad checksum assign ignored
    send(mk(8'h7F, 8'h06, 8'hB0, 8'h3A, 8'h00, FID[7:0], FID[15:8], 8'h44), 1'b0);
    check(node_nad == NAD0, "R8 assign", 64'(node_nad), 64'(NAD0));

    // R4 erase
    send(mk(NAD0, 8'h06, 8'h31, 8'hFF, 8'h00, 8'h02, 8'h04, 8'h03), 1'b1);
    check(c_erase && erase_page == 16'h0402 && erase_count == 8'd3, "R4",
          {c_erase, erase_page, erase_count}, {1'b1, 16'h0402, 8'd3});
    send(mk(NAD0, 8'h06, 8'h31, 8'hFF, 8'h00, 8'h02, 8'h04, 8'h00), 1'b1);
    check(!c_erase, "R4 zero", 64'(c_erase), 64'd0);
    send(mk(NAD0, 8'h06, 8'h31, 8'hFF, 8'h00, 8'h02, 8'h04, 8'h03), 1'b0);
    check(!c_erase, "R8 erase", 64'(c_erase), 64'd0);

    // R5/R6 window sweep over 1..3 pages
    for (int n = 1; n <= 3; n++) begin
      send(mk(NAD0, 8'h04, 8'h34, 8'h01, 8'h00, 8'(n), 8'hFF, 8'hFF), 1'b1);
      check(win_open, "R5 open", 64'(win_open), 64'd1);
      for (int k = 0; k < n * WPP; k++) begin
        logic [31:0] w;
        w = 32'hA1B2_0000 + 32'(n * 16 + k);
        send(xfer(NAD0, w), 1'b1);
        check(c_wr && c_word == w, "R5 word", {c_wr, c_word}, {1'b1, w});
        check(win_open == (k != n * WPP - 1), "R6 close", 64'(win_open),
              64'(k != n * WPP - 1));
      end
      send(xfer(NAD0, 32'hDEAD_BEEF), 1'b1);
      check(!c_wr, "R6 extra", 64'(c_wr), 64'd0);
    end

    // R7 foreign frame keeps window, addressed frame closes it
    send(mk(NAD0, 8'h04, 8'h34, 8'h00, 8'h00, 8'd2, 8'hFF, 8'hFF), 1'b1);
    send(xfer(NAD0, 32'h1111_2222), 1'b1);
    send(mk(8'h33, 8'h06, 8'hB2, 8'h00, 8'h3A, 8'h00, 8'hFF, 8'hFF), 1'b1);
    check(win_open, "R7 foreign", 64'(win_open), 64'd1);
    send(mk(NAD0, 8'h06, 8'hB2, 8'h05, 8'h3A, 8'h00, 8'hFF, 8'hFF), 1'b1);
    check(!win_open, "R7 addressed", 64'(win_open), 64'd0);
    send(xfer(NAD0, 32'h3333_4444), 1'b1);
    check(!c_wr, "R7 after close", 64'(c_wr), 64'd0);
    // R7 bad checksum transfer closes the window
    send(mk(NAD0, 8'h04, 8'h34, 8'h00, 8'h00, 8'd1, 8'hFF, 8'hFF), 1'b1);
    send(xfer(NAD0, 32'h5555_6666), 1'b0);
    check(!c_wr && !win_open, "R7 bad cksum", {c_wr, win_open}, 2'b00);

    // R9 check routine
    send(mk(NAD0, 8'h06, 8'h31, 8'hFF, 8'h01, 8'h07, 8'h00, 8'h02), 1'b1);
    check(c_chk && chk_page == 16'h0007 && chk_count == 8'd2 && !req_ready, "R9 req",
          {c_chk, chk_page, chk_count, req_ready}, {1'b1, 16'h0007, 8'd2, 1'b0});
    repeat (2) @(negedge clk);
    check(!req_ready, "R9 stall", 64'(req_ready), 64'd0);
    chk_done = 1'b1; chk_sum = 32'h0102_A3C4;
    @(negedge clk);
    chk_done = 1'b0;
    exp = mk(NAD0, 8'h05, 8'h71, 8'hC4, 8'hA3, 8'h02, 8'h01, 8'hFF);
    check(rsp_valid && rsp_bytes == exp && req_ready, "R9 rsp", rsp_bytes, exp);
    serve();

    // R10 reset
    send(mk(NAD0, 8'h02, 8'h11, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF), 1'b1);
    check(c_rst && !c_erase && !c_wr && !c_chk, "R10", 64'(c_rst), 64'd1);
    send(mk(NAD0, 8'h02, 8'h11, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF), 1'b0);
    check(!c_rst, "R8 reset", 64'(c_rst), 64'd0);
    // R12 only one pulse per frame (also asserted in RTL)
    check(!(c_rst && c_erase), "R12", {c_rst, c_erase}, 2'b00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule